// File: doc/BRIEF.md
# Memory Controller Configuration and Chip-Select Decoder

This block holds the setup state of an external memory controller and turns system addresses into chip-select decisions. Software reaches the state through a small register port that takes a 32-bit word index, a write strobe, write data and returns read data. It writes a global control word, a shared base-address mask, and one configuration word and one timing word per chip select. A read-only word reports the four power-on strap bits.

The decode side is purely combinational. Each system address is compared against every enabled chip select's 8-bit select field, above bit 22, under the shared mask. The lowest-numbered matching chip select drives a one-hot select vector and a hit flag. Its memory type, bus width and timing word are presented to the memory sequencer that sits downstream. Reset leaves chip select 0 enabled, with its type and width taken from the straps, so boot code can fetch before any register is written.

Top module: `mcc_top`

## Requirements
- R1: Register word indices (byte offset divided by 4) are: control 0, strap 1, mask 2; chip select i has configuration at 4+2i and timing at 5+2i, for i in 0..7. Each reads back the value last stored.
- R2: Word 1 reads {28'b0, straps sampled during reset}, and writes to it change nothing.
- R3: Writes keep only the valid bits: control keeps 0xFF000703, configuration keeps 0x00FF0FFF, mask keeps bits [9:0], and timing keeps all 32 bits.
- R4: After reset, control, mask, configuration 1..7 and all timing words except 0 read zero. Configuration 0 reads 1 | strap[3:2]<<1 | strap[1:0]<<4.
- R5: After reset, timing 0 depends on strap[3:2]: 0 gives 0x0FFF83FF, 1 gives 0x00000000, 2 gives 0x03FFFFFF, 3 gives 0x01FFFFFF.
- R6: Chip select i matches when configuration bit 0 is set and (addr & (mask<<22)) == ((cfg[23:16]<<22) & (mask<<22)).
- R7: A chip select whose enable bit is clear never drives its select line, whatever its select field.
- R8: When several chip selects match, only the lowest-numbered one is driven. The select vector is one-hot or zero, and hit_o is set exactly when it is nonzero.
- R9: mem_type_o is cfg[2:1], bus_width_o is cfg[5:4] and timing_o is the timing word of the selected chip select. All three are zero when there is no hit.
- R10: Word indices 3 and 20 and above read zero, and writes to them leave every register unchanged.
- R11: Read data is registered. It shows the addressed word one clock edge after the address is applied, and the earlier value until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 4 | Power-on straps: [3:2] memory type, [1:0] bus width |
| reg_addr_i | input | REG_AW (6) | Register word index |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| sys_addr_i | input | ADDR_W (32) | System address to decode |
| cs_o | output | NUM_CS (8) | One-hot chip-select vector |
| hit_o | output | 1 | Some chip select is selected |
| mem_type_o | output | 2 | Memory type of the selected chip select |
| bus_width_o | output | 2 | Bus width of the selected chip select |
| timing_o | output | 32 | Timing word of the selected chip select |

## Verification
The bench builds the block with its default parameters: eight chip selects, a 32-bit system address, a 10-bit mask placed at bit 22 and a 6-bit register index. With these values the index runs past the end of the window, so accesses to unmapped words are reachable. Random select fields are drawn from a handful of values, and masks from a short list that includes all-ones and zero. This makes overlapping matches frequent, which exercises the priority choice between several enabled chip selects. Each of the four strap encodings is applied across a reset to reach every boot timing value.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  typedef enum logic [1:0] {
    MEM_SDRAM = 2'd0,
    MEM_SSRAM = 2'd1,
    MEM_ASYNC = 2'd2,
    MEM_SYNC  = 2'd3
  } mem_kind_e;

  localparam int unsigned W_CTRL    = 0;
  localparam int unsigned W_STRAP   = 1;
  localparam int unsigned W_MASK    = 2;
  localparam int unsigned W_CS_BASE = 4;

  localparam logic [31:0] CTRL_KEEP = 32'hFF00_0703;
  localparam logic [31:0] CFG_KEEP  = 32'h00FF_0FFF;

  localparam int unsigned CFG_EN_BIT   = 0;
  localparam int unsigned CFG_TYPE_LSB = 1;
  localparam int unsigned CFG_BW_LSB   = 4;
  localparam int unsigned CFG_SEL_LSB  = 16;

  function automatic logic [31:0] boot_timing(input mem_kind_e k);
    case (k)
      MEM_SDRAM: return 32'h0FFF_83FF;
      MEM_SSRAM: return 32'h0000_0000;
      MEM_ASYNC: return 32'h03FF_FFFF;
      default:   return 32'h01FF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] boot_config(input logic [3:0] strap);
    return 32'(1) | (32'(strap[3:2]) << CFG_TYPE_LSB) | (32'(strap[1:0]) << CFG_BW_LSB);
  endfunction
endpackage

// File: rtl/mcc_regs.sv
module mcc_regs
  import mcc_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned REG_AW = 6,
  parameter int unsigned MASK_W = 10,
  parameter int unsigned SEL_W  = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [3:0]                        strap_i,
  input  logic [REG_AW-1:0]                 reg_addr_i,
  input  logic                              reg_we_i,
  input  logic [31:0]                       reg_wdata_i,
  output logic [31:0]                       reg_rdata_o,
  output logic [NUM_CS-1:0]                 cs_en_o,
  output logic [NUM_CS-1:0][1:0]            cs_type_o,
  output logic [NUM_CS-1:0][1:0]            cs_bw_o,
  output logic [NUM_CS-1:0][SEL_W-1:0]      cs_sel_o,
  output logic [NUM_CS-1:0][31:0]           cs_tim_o,
  output logic [MASK_W-1:0]                 mask_o
);
  localparam int unsigned WIN_WORDS = W_CS_BASE + 2 * NUM_CS;

  logic [31:0]              word_ext;
  logic [31:0]              csr_q;
  logic [3:0]               poc_q;
  logic [MASK_W-1:0]        mask_q;
  logic [NUM_CS-1:0][31:0]  cfg_q;
  logic [NUM_CS-1:0][31:0]  tim_q;
  logic [31:0]              rd_next;

  assign word_ext = 32'(reg_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_q  <= '0;
      poc_q  <= strap_i;
      mask_q <= '0;
    end else if (reg_we_i) begin
      if (word_ext == 32'(W_CTRL)) csr_q  <= reg_wdata_i & CTRL_KEEP;
      if (word_ext == 32'(W_MASK)) mask_q <= reg_wdata_i[MASK_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    localparam int unsigned CFG_WORD = W_CS_BASE + 2 * g;
    localparam int unsigned TIM_WORD = CFG_WORD + 1;
    logic [31:0] cfg_rst, tim_rst;

    if (g == 0) begin : g_boot
      assign cfg_rst = boot_config(strap_i);
      assign tim_rst = boot_timing(mem_kind_e'(strap_i[3:2]));
    end else begin : g_plain
      assign cfg_rst = '0;
      assign tim_rst = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[g] <= cfg_rst;
        tim_q[g] <= tim_rst;
      end else if (reg_we_i) begin
        if (word_ext == 32'(CFG_WORD)) cfg_q[g] <= reg_wdata_i & CFG_KEEP;
        if (word_ext == 32'(TIM_WORD)) tim_q[g] <= reg_wdata_i;
      end
    end

    assign cs_en_o[g]   = cfg_q[g][CFG_EN_BIT];
    assign cs_type_o[g] = cfg_q[g][CFG_TYPE_LSB +: 2];
    assign cs_bw_o[g]   = cfg_q[g][CFG_BW_LSB +: 2];
    assign cs_sel_o[g]  = cfg_q[g][CFG_SEL_LSB +: SEL_W];
    assign cs_tim_o[g]  = tim_q[g];
  end

  always_comb begin
    rd_next = '0;
    if (word_ext == 32'(W_CTRL))       rd_next = csr_q;
    else if (word_ext == 32'(W_STRAP)) rd_next = 32'(poc_q);
    else if (word_ext == 32'(W_MASK))  rd_next = 32'(mask_q);
    else if (word_ext >= 32'(W_CS_BASE) && word_ext < 32'(WIN_WORDS)) begin
      for (int i = 0; i < NUM_CS; i++) begin
        if (word_ext == 32'(W_CS_BASE + 2 * i))     rd_next = cfg_q[i];
        if (word_ext == 32'(W_CS_BASE + 2 * i + 1)) rd_next = tim_q[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) reg_rdata_o <= '0;
    else         reg_rdata_o <= rd_next;
  end

  assign mask_o = mask_q;

  // R2
  strap_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(poc_q));

  // R3
  mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && word_ext == 32'(W_MASK)) |=> mask_q == $past(reg_wdata_i[MASK_W-1:0]));

  // R10
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && (word_ext == 32'd3 || word_ext >= 32'(WIN_WORDS)))
      |=> ($stable(cfg_q) && $stable(tim_q) && $stable(csr_q) && $stable(mask_q)));
endmodule

// File: rtl/mcc_match.sv
module mcc_match #(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 10,
  parameter int unsigned SEL_W  = 8,
  parameter int unsigned SHIFT  = 22
) (
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [MASK_W-1:0]            mask_i,
  input  logic [NUM_CS-1:0]            en_i,
  input  logic [NUM_CS-1:0][SEL_W-1:0] sel_i,
  output logic [NUM_CS-1:0]            match_o
);
  logic [ADDR_W-1:0] mask_ext;
  assign mask_ext = ADDR_W'(mask_i) << SHIFT;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cmp
    logic [ADDR_W-1:0] sel_ext;
    assign sel_ext    = ADDR_W'(sel_i[g]) << SHIFT;
    assign match_o[g] = en_i[g] && ((addr_i & mask_ext) == (sel_ext & mask_ext));
  end
endmodule

// File: rtl/mcc_pick.sv
module mcc_pick #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/mcc_top.sv
module mcc_top #(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REG_AW = 6,
  parameter int unsigned MASK_W = 10,
  parameter int unsigned SEL_W  = 8,
  parameter int unsigned SHIFT  = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        strap_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [ADDR_W-1:0] sys_addr_i,
  output logic [NUM_CS-1:0] cs_o,
  output logic              hit_o,
  output logic [1:0]        mem_type_o,
  output logic [1:0]        bus_width_o,
  output logic [31:0]       timing_o
);
  localparam int unsigned IW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [NUM_CS-1:0]            en;
  logic [NUM_CS-1:0][1:0]       kind;
  logic [NUM_CS-1:0][1:0]       bw;
  logic [NUM_CS-1:0][SEL_W-1:0] sel;
  logic [NUM_CS-1:0][31:0]      tim;
  logic [MASK_W-1:0]            mask;
  logic [NUM_CS-1:0]            match;
  logic [IW-1:0]                win_idx;
  logic                         any;

  mcc_regs #(
    .NUM_CS(NUM_CS), .REG_AW(REG_AW), .MASK_W(MASK_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .strap_i     (strap_i),
    .reg_addr_i  (reg_addr_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .cs_en_o     (en),
    .cs_type_o   (kind),
    .cs_bw_o     (bw),
    .cs_sel_o    (sel),
    .cs_tim_o    (tim),
    .mask_o      (mask)
  );

  mcc_match #(
    .NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .MASK_W(MASK_W), .SEL_W(SEL_W), .SHIFT(SHIFT)
  ) u_match (
    .addr_i  (sys_addr_i),
    .mask_i  (mask),
    .en_i    (en),
    .sel_i   (sel),
    .match_o (match)
  );

  mcc_pick #(.N(NUM_CS)) u_pick (
    .req_i   (match),
    .grant_o (cs_o),
    .idx_o   (win_idx),
    .any_o   (any)
  );

  assign hit_o       = any;
  assign mem_type_o  = any ? kind[win_idx] : '0;
  assign bus_width_o = any ? bw[win_idx]   : '0;
  assign timing_o    = any ? tim[win_idx]  : '0;

  // R8
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));

  // R8
  hit_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o == (cs_o != '0));

  // R8
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cs_o - NUM_CS'(1)) & match) == '0);

  // R7
  no_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o & ~en) == '0);

  // R9
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (timing_o == '0 && mem_type_o == '0 && bus_width_o == '0));
endmodule

// File: tb/mcc_top_tb.sv
module mcc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 8;
  localparam int RAW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [3:0]      strap = 4'd0;
  logic [RAW-1:0]  reg_addr = '0;
  logic            reg_we = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [31:0]     sys_addr = '0;
  logic [NCS-1:0]  cs;
  logic            hit;
  logic [1:0]      mem_type, bus_width;
  logic [31:0]     timing;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_csr, m_mask;
  logic [3:0]  m_poc;
  logic [31:0] m_cfg [NCS];
  logic [31:0] m_tim [NCS];

  always #(CLK_PERIOD/2) clk = ~clk;

  mcc_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .sys_addr_i(sys_addr), .cs_o(cs), .hit_o(hit),
    .mem_type_o(mem_type), .bus_width_o(bus_width), .timing_o(timing)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: act=running exp=finished");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] boot_tim(input logic [1:0] k);
    case (k)
      2'd0: return 32'h0FFF83FF;
      2'd1: return 32'h00000000;
      2'd2: return 32'h03FFFFFF;
      default: return 32'h01FFFFFF;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input int w);
    if (w == 0) return m_csr;
    if (w == 1) return {28'b0, m_poc};
    if (w == 2) return m_mask;
    if (w >= 4 && w < 4 + 2*NCS) return (w % 2 == 1) ? m_tim[(w-4)/2] : m_cfg[(w-4)/2];
    return 32'h0;
  endfunction

  function automatic int exp_idx(input logic [31:0] a);
    logic [31:0] m;
    m = m_mask << 22;
    for (int i = 0; i < NCS; i++)
      if (m_cfg[i][0] && ((a & m) == (({24'b0, m_cfg[i][23:16]} << 22) & m))) return i;
    return -1;
  endfunction

  task automatic do_reset(input logic [3:0] s);
    @(negedge clk);
    strap = s; rst_n = 1'b0; reg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_csr = 0; m_mask = 0; m_poc = s;
    for (int i = 0; i < NCS; i++) begin m_cfg[i] = 0; m_tim[i] = 0; end
    m_cfg[0] = 32'd1 | ({30'b0, s[3:2]} << 1) | ({30'b0, s[1:0]} << 4);
    m_tim[0] = boot_tim(s[3:2]);
  endtask

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    reg_addr = RAW'(w); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (w == 0) m_csr = d & 32'hFF000703;
    else if (w == 2) m_mask = d & 32'h3FF;
    else if (w >= 4 && w < 4 + 2*NCS) begin
      if (w % 2 == 1) m_tim[(w-4)/2] = d;
      else m_cfg[(w-4)/2] = d & 32'h00FF0FFF;
    end
  endtask

  task automatic rd(input int w, output logic [31:0] v);
    @(negedge clk);
    reg_addr = RAW'(w); reg_we = 1'b0;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input int w);
    logic [31:0] v;
    rd(w, v);
    chk(req, v, exp_read(w));
  endtask

  task automatic dec_chk(input logic [31:0] a);
    int e;
    logic [NCS-1:0] ecs;
    @(negedge clk);
    sys_addr = a;
    #1;
    e = exp_idx(a);
    ecs = (e >= 0) ? NCS'(1) << e : '0;
    chk("R6/R7/R8 cs", {24'b0, cs}, {24'b0, ecs});
    chk("R8 hit", {31'b0, hit}, {31'b0, (e >= 0)});
    chk("R9 type", {30'b0, mem_type}, (e >= 0) ? {30'b0, m_cfg[e][2:1]} : 32'h0);
    chk("R9 width", {30'b0, bus_width}, (e >= 0) ? {30'b0, m_cfg[e][5:4]} : 32'h0);
    chk("R9 timing", timing, (e >= 0) ? m_tim[e] : 32'h0);
  endtask

  logic [31:0] mask_pool [5] = '{32'h3FF, 32'h0FF, 32'h0F0, 32'h000, 32'h003};

  initial begin
    logic [31:0] v, hold;
    void'($urandom(32'h5EED_1234));

    // R4 R5 R2: every strap encoding across reset
    for (int s = 0; s < 4; s++) begin
      do_reset(4'(s * 4 + (3 - s)));
      if (s == 0) chk("R11 rdata reset", reg_rdata, 32'h0);
      rd_chk("R4 cfg0", 4);
      rd_chk("R5 tim0", 5);
      rd_chk("R2 strap", 1);
      rd_chk("R4 ctrl", 0);
      rd_chk("R4 mask", 2);
      rd_chk("R4 cfg3", 10);
      rd_chk("R4 tim6", 17);
      dec_chk($urandom());
    end

    do_reset(4'b1001);
    // R2
    wr(1, 32'hFFFF_FFFF);
    rd_chk("R2 strap ro", 1);
    // R3
    wr(2, 32'hFFFF_FFFF);  rd_chk("R3 mask keep", 2);
    wr(0, 32'hFFFF_FFFF);  rd_chk("R3 ctrl keep", 0);
    wr(8, 32'hFFFF_FFFF);  rd_chk("R3 cfg keep", 8);
    wr(15, 32'hFFFF_FFFF); rd_chk("R3 tim keep", 15);
    // R1
    for (int w = 0; w < 4 + 2*NCS; w++) if (w != 1 && w != 3) wr(w, $urandom());
    for (int w = 0; w < 4 + 2*NCS; w++) rd_chk("R1 map", w);
    // R10
    wr(3, 32'hDEAD_BEEF);
    for (int w = 20; w < 64; w += 7) wr(w, 32'hFFFF_FFFF);
    wr(63, 32'h1234_5678);
    rd_chk("R10 word3", 3);
    rd_chk("R10 word20", 20);
    rd_chk("R10 word63", 63);
    for (int w = 0; w < 4 + 2*NCS; w++) rd_chk("R10 untouched", w);

    // R11
    wr(19, 32'hA5A5_0F0F);
    rd(0, hold);
    @(negedge clk);
    reg_addr = RAW'(19);
    #1 chk("R11 before edge", reg_rdata, hold);
    @(negedge clk);
    chk("R11 after edge", reg_rdata, 32'hA5A5_0F0F);

    // R6 R7 R8 directed overlap
    for (int i = 0; i < NCS; i++) wr(4 + 2*i, 32'h0);
    wr(2, 32'h3FF);
    wr(6, 32'h0005_0013);  wr(7, 32'h1111_1111);
    wr(12, 32'h0005_0025); wr(13, 32'h4444_4444);
    dec_chk(32'h0140_0ABC);
    wr(6, 32'h0005_0012);
    dec_chk(32'h0140_0ABC);
    dec_chk(32'h0180_0000);
    dec_chk(32'h4140_0000);
    wr(2, 32'h0);
    dec_chk(32'hFFFF_FFFF);
    wr(12, 32'h0);
    dec_chk(32'h0000_1000);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op < 4) begin
        int w;
        logic [31:0] d;
        w = int'($urandom_range(0, 24));
        d = $urandom();
        if (w == 2) d = mask_pool[$urandom_range(0, 4)] | (d & 32'hFFFF_FC00);
        if (w >= 4 && w < 20 && (w % 2 == 0)) d[23:16] = 8'($urandom_range(0, 3));
        wr(w, d);
      end else if (op < 6) begin
        rd_chk("R1 random read", int'($urandom_range(0, 63)));
      end else begin
        logic [31:0] a;
        a = {2'b00, 8'($urandom_range(0, 3)), 22'($urandom())};
        if ($urandom_range(0, 7) == 0) a[31:30] = 2'($urandom());
        dec_chk(a);
      end
    end

    summary();
    $finish;
  end
endmodule